// File: doc/BRIEF.md
# Status and Interrupt Acknowledge Controller

This block watches four status levels from a power-management core: undervoltage, power-up sequence complete, thermal shutdown and thermal warning. It presents two byte-wide registers. The sense register shows the current level of each source. The acknowledge register records that a source has changed and keeps that record until software reads it. Any recorded change drives one interrupt line towards the host processor.

Each source level passes through a two-flop synchroniser before it is used. The synchronised level is the sense bit. The acknowledge logic compares each sense bit with its value from the previous cycle. The undervoltage and both thermal sources are recorded on a change in either direction. The sequence-complete source is recorded only when it rises. A read strobe that carries the acknowledge address clears the record. A change detected in the same cycle as that read survives the clear. The hardware enable pin is synchronised the same way, and while it is low the acknowledge register is held clear.

Top module: `stat_irq_ctrl`

## Requirements
- R1: `sense_reg` bit 3 is undervoltage, bit 2 is sequence complete, bit 1 is thermal shutdown and bit 0 is thermal warning. These are inputs `src_lvl[3:0]` in the same positions. Bits 7..4 read 0. A level change on `src_lvl` appears on `sense_reg` after the second rising clock edge.
- R2: After reset, `sense_reg` is 0x04, `ack_reg` is 0x00 and `irq` is 0.
- R3: `ack_reg` uses the same bit positions as `sense_reg`, and bits 7..4 read 0.
- R4: The undervoltage, thermal-shutdown and thermal-warning bits of `ack_reg` set on either a rising or a falling change of their sense bit. The bit shows on the third rising edge after the input change, and stays set until it is cleared.
- R5: The sequence-complete bit of `ack_reg` sets on a rising change of its sense bit only. A falling change leaves it unchanged.
- R6: A clock cycle with `rd_stb` high and `rd_addr` equal to 0x0B clears `ack_reg` at that edge. A strobe with any other address, including the sense address 0x0A, leaves `ack_reg` unchanged.
- R7: `hw_en` is synchronised through two flops. While the synchronised value is low, `ack_reg` is held at 0x00 and source changes are not recorded. `sense_reg` keeps following the sources.
- R8: A source change whose acknowledge bit sets at the same edge as a clearing read stays set after that read. All other bits clear.
- R9: `irq` is 1 exactly when `ack_reg` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_lvl | input | 4 | Raw source levels: bit 3 undervoltage, bit 2 sequence complete, bit 1 thermal shutdown, bit 0 thermal warning |
| rd_stb | input | 1 | Register read strobe, one cycle per access |
| rd_addr | input | 8 | Register address of the read |
| hw_en | input | 1 | Hardware enable pin, asynchronous to `clk` |
| sense_reg | output | 8 | Live sense register value |
| ack_reg | output | 8 | Latched acknowledge register value |
| irq | output | 1 | Interrupt request, high while any acknowledge bit is set |

## Verification
A faulty synchroniser or a wrong previous-value register shows up as a sense bit that moves at the wrong edge. It can also show up as an acknowledge bit that is set or missing three edges after a source change. Both are visible on `sense_reg` and `ack_reg` within four cycles. A wrong edge polarity for the sequence-complete source sets an acknowledge bit after a falling change. Swapped priority between clear and set loses the change that coincides with a read. A broken enable path leaves `irq` high while the pin is low. Each of these faults is visible on `ack_reg` and `irq` in the cycle after the stimulus settles.

// File: rtl/stat_irq_pkg.sv
// Shared constants for the status and interrupt acknowledge controller.
// Assumes four sources packed into the low nibble of each register.
package stat_irq_pkg;
    localparam int unsigned NUM_SRC = 4;
    localparam int unsigned REG_W   = 8;
    localparam int unsigned ADDR_W  = 8;

    // Bit positions shared by the sense and acknowledge registers
    localparam int unsigned BIT_WARN = 0;
    localparam int unsigned BIT_TSD  = 1;
    localparam int unsigned BIT_SEQ  = 2;
    localparam int unsigned BIT_UV   = 3;

    localparam logic [ADDR_W-1:0] ADDR_SENSE = 8'h0A;
    localparam logic [ADDR_W-1:0] ADDR_ACK   = 8'h0B;

    // Reset level of the synchronised sources (sequence complete reads high)
    localparam logic [NUM_SRC-1:0] SRC_RST = 4'b0100;
    // Sources that record both edges; the rest record rising edges only
    localparam logic [NUM_SRC-1:0] BOTH_EDGE_MASK = 4'b1011;
endpackage

// File: rtl/stat_sync.sv
// Two-flop synchroniser for a vector of asynchronous levels.
// Assumes each bit is independent; no multi-bit coherence is provided.
module stat_sync #(
    parameter int unsigned   W       = 4,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Two register stages with a synchronous reset to RST_VAL
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= d_async;
            stage2 <= stage1;
        end
    end

    assign q_sync = stage2;
endmodule

// File: rtl/stat_edge_latch.sv
// Per-bit change detector and sticky acknowledge register.
// Each bit records both edges or only rising edges, as BOTH_EDGE selects.
// A clearing read and a new edge in the same cycle keep the new edge.
// Assumes cur is already synchronous to clk.
module stat_edge_latch #(
    parameter int unsigned  N         = 4,
    parameter logic [N-1:0] RST_VAL   = '0,
    parameter logic [N-1:0] BOTH_EDGE = '1,
    parameter int unsigned  SEQ_BIT   = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cur,
    input  logic         en,
    input  logic         clr,
    output logic [N-1:0] ack
);
    logic [N-1:0] prev;
    logic [N-1:0] hit;

    // Keep the previous synchronised level for change detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= cur;
    end

    // Select the edge polarity for each bit
    for (genvar i = 0; i < N; i++) begin : g_edge
        if (BOTH_EDGE[i]) begin : g_both
            assign hit[i] = cur[i] ^ prev[i];
        end else begin : g_rise
            assign hit[i] = cur[i] & ~prev[i];
        end
    end

    // Sticky acknowledge: clear on read or while disabled, new edges win over clear
    always_ff @(posedge clk) begin
        if (!rst_n)      ack <= '0;
        else if (!en)    ack <= '0;
        else if (clr)    ack <= hit;
        else             ack <= ack | hit;
    end

    AST_SEQ_FALL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && prev[SEQ_BIT] && !cur[SEQ_BIT] && !ack[SEQ_BIT]) |=> !ack[SEQ_BIT]); // R5
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && clr && hit == '0) |=> (ack == '0)); // R6
    AST_EDGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && hit != '0) |=> ((ack & $past(hit)) == $past(hit))); // R8
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (ack == '0)); // R7
endmodule

// File: rtl/stat_irq_ctrl.sv
// Status and interrupt acknowledge controller top.
// Synchronises the sources and the enable pin, then builds the live sense
// register, the clear-on-read acknowledge register and the interrupt line.
// Assumes reads arrive as a one-cycle strobe with an address.
module stat_irq_ctrl
    import stat_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        src_lvl,
    input  logic              rd_stb,
    input  logic [7:0]        rd_addr,
    input  logic              hw_en,
    output logic [7:0]        sense_reg,
    output logic [7:0]        ack_reg,
    output logic              irq
);
    localparam int unsigned PAD_W = REG_W - NUM_SRC;

    logic [NUM_SRC-1:0] src_s;
    logic               en_s;
    logic [NUM_SRC-1:0] ack_bits;
    logic               rd_clr;

    stat_sync #(.W(NUM_SRC), .RST_VAL(SRC_RST)) u_src_sync (
        .clk(clk), .rst_n(rst_n), .d_async(src_lvl), .q_sync(src_s)
    );

    stat_sync #(.W(1), .RST_VAL(1'b0)) u_en_sync (
        .clk(clk), .rst_n(rst_n), .d_async(hw_en), .q_sync(en_s)
    );

    // A read of the acknowledge address requests a clear
    assign rd_clr = rd_stb && (rd_addr == ADDR_ACK);

    stat_edge_latch #(
        .N(NUM_SRC), .RST_VAL(SRC_RST), .BOTH_EDGE(BOTH_EDGE_MASK), .SEQ_BIT(BIT_SEQ)
    ) u_latch (
        .clk(clk), .rst_n(rst_n), .cur(src_s), .en(en_s), .clr(rd_clr), .ack(ack_bits)
    );

    // Pad both registers to a byte with zero upper bits
    assign sense_reg = {{PAD_W{1'b0}}, src_s};
    assign ack_reg   = {{PAD_W{1'b0}}, ack_bits};
    assign irq       = |ack_bits;

    AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !$changed(sense_reg)) |=> !irq); // R9
endmodule

// File: tb/stat_irq_ctrl_test.sv
module stat_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src_lvl = 4'b0100;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_addr = 8'h00;
    logic       hw_en = 1'b1;
    logic [7:0] sense_reg, ack_reg;
    logic       irq;
    int         n_run = 0;
    int         n_fail = 0;
    logic       done = 1'b0;

    always #5 clk = ~clk;

    stat_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .rd_stb(rd_stb),
        .rd_addr(rd_addr), .hw_en(hw_en), .sense_reg(sense_reg),
        .ack_reg(ack_reg), .irq(irq)
    );

    // Vector: {src[3:0], clear-after, exp_sense[3:0], exp_ack[3:0]}
    localparam logic [12:0] VEC [9] = '{
        {4'b0001, 1'b1, 4'h1, 4'h1},
        {4'b0000, 1'b1, 4'h0, 4'h1},
        {4'b0100, 1'b1, 4'h4, 4'h4},
        {4'b0000, 1'b0, 4'h0, 4'h0},
        {4'b1010, 1'b0, 4'hA, 4'hA},
        {4'b1011, 1'b1, 4'hB, 4'hB},
        {4'b0011, 1'b1, 4'h3, 4'h8},
        {4'b0111, 1'b1, 4'h7, 4'h4},
        {4'b0110, 1'b1, 4'h6, 4'h1}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd_pulse(input logic [7:0] a);
        rd_stb = 1'b1; rd_addr = a;
        @(posedge clk);
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R2 sense reset", sense_reg, 8'h04);
        chk("R2 ack reset", ack_reg, 8'h00);
        chk("R2 irq reset", {7'd0, irq}, 8'h00);

        // Falling sequence-complete after reset: not recorded
        src_lvl = 4'b0000;
        @(posedge clk); @(negedge clk);
        chk("R1 sense after one edge", sense_reg, 8'h04);
        settle(3);
        chk("R1 sense follows", sense_reg, 8'h00);
        chk("R5 seq fall ignored", ack_reg, 8'h00);

        for (int i = 0; i < 9; i++) begin
            src_lvl = VEC[i][12:9];
            settle(4);
            chk("R1 R3 vector sense", sense_reg, {4'h0, VEC[i][7:4]});
            chk("R4 R5 vector ack", ack_reg, {4'h0, VEC[i][3:0]});
            chk("R9 vector irq", {7'd0, irq}, {7'd0, VEC[i][3:0] != 4'h0});
            if (VEC[i][8]) begin
                rd_pulse(8'h0B);
                chk("R6 clear on read", ack_reg, 8'h00);
            end
        end

        // Undervoltage timing: visible at the third edge, not before
        src_lvl = 4'b1110;
        settle(2);
        chk("R4 ack not before third edge", ack_reg, 8'h00);
        settle(1);
        chk("R4 ack at third edge", ack_reg, 8'h08);

        // Warning edge lands in the same cycle as a clearing read
        src_lvl = 4'b1111;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd_stb = 1'b1; rd_addr = 8'h0B;
        @(posedge clk); @(negedge clk);
        rd_stb = 1'b0;
        chk("R8 edge kept through read", ack_reg, 8'h01);

        // Other addresses leave the record alone
        rd_pulse(8'h0A);
        chk("R6 sense read keeps ack", ack_reg, 8'h01);
        rd_pulse(8'h05);
        chk("R6 other read keeps ack", ack_reg, 8'h01);
        chk("R9 irq held", {7'd0, irq}, 8'h01);
        rd_pulse(8'h0B);
        chk("R9 irq drops", {7'd0, irq}, 8'h00);

        // Enable pin low clears and blocks recording
        src_lvl = 4'b1101;
        settle(4);
        chk("R4 tsd fall", ack_reg, 8'h02);
        hw_en = 1'b0;
        settle(4);
        chk("R7 enable low clears", ack_reg, 8'h00);
        chk("R7 irq low", {7'd0, irq}, 8'h00);
        src_lvl = 4'b0101;
        settle(4);
        chk("R7 sense still live", sense_reg, 8'h05);
        chk("R7 no record while disabled", ack_reg, 8'h00);
        hw_en = 1'b1;
        settle(4);
        chk("R7 re-enable stays clear", ack_reg, 8'h00);
        src_lvl = 4'b0100;
        settle(4);
        chk("R7 records after enable", ack_reg, 8'h01);
        chk("R9 irq after enable", {7'd0, irq}, 8'h01);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule